// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a 4096-word by 1-bit asynchronous static RAM. The RAM has a 12-bit address, separate data-in and data-out bits, an active-low chip select and an active-low write enable. The host hands over one word access at a time on a valid/ready request channel. A request carries an address, a write flag and one write bit. The controller then runs the RAM control pins through a cycle whose phase lengths are counted in clocks of the system clock. Every phase length is derived from nanosecond parameters and rounded up to whole clock periods.

A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops on the next cycle and stays low until the RAM cycle has finished, so the host applies back-pressure simply by holding `req_valid` with stable fields. The read response is a one-cycle strobe on `rsp_valid` with the data on `rsp_rdata`. The response path has no ready input, so the host must be able to take the strobe whenever it arrives. Writes produce no response.

All RAM pins come from flops. Between accesses the chip is deselected, write enable is high and the address bus keeps its last value.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high, and after its release until the first transfer, `ram_cs_n` is 1, `ram_we_n` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: While no cycle is in progress, `ram_cs_n` and `ram_we_n` are both 1 and `ram_addr` keeps the address of the last access.
- R3: A request transfers only when `req_valid` and `req_ready` are both high. `req_ready` is 0 in the cycle after a transfer and stays 0 until the cycle ends. A held request waits without disturbing the cycle in progress.
- R4: `ram_we_n` is 0 only while `ram_cs_n` is 0. Chip select and address are applied for at least ceil(max(25 ns, 10 ns)/period) cycles before write enable falls, which is 3 cycles at 100 MHz.
- R5: The write enable pulse lasts at least ceil(max(50 ns, 35 ns)/period) cycles, which is 5 cycles. Chip select and address are active for at least ceil(85 ns/period) cycles, which is 9 cycles, up to the end of the pulse.
- R6: `ram_addr` and `ram_din` do not change while `ram_we_n` is 0. They stay unchanged for at least one cycle after `ram_we_n` rises, and chip select stays low during that cycle.
- R7: A write keeps chip select low for at least ceil(135 ns/period) cycles, which is 14 cycles.
- R8: A read keeps chip select low with write enable high for exactly ceil(135 ns/period) cycles, which is 14 cycles. It samples `ram_dout` during the last of those cycles. It raises `rsp_valid` for exactly one cycle, on the same edge where chip select returns high.
- R9: A write never raises `rsp_valid`.
- R10: A read returns on `rsp_rdata` the bit last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 12 | Word address of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 1 | Read data |
| ram_addr | output | 12 | RAM address bus |
| ram_din | output | 1 | RAM data-in bit |
| ram_dout | input | 1 | RAM data-out bit |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
A sequencer stuck in a wrong phase, or a phase counter loaded with the wrong length, shows up within one RAM cycle. The symptom is a chip-select window or write-enable pulse whose length differs from its counted minimum, or a write-enable edge seen while chip select is high. A read window that ends early samples data before the RAM model drives it valid, so the returned bit is wrong and the mismatch appears on the very response strobe. A lost or duplicated response, or a write that raises the strobe, empties or overflows the scoreboard by the end of the next access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV
  } seq_state_t;

  // Round a time in ns up to whole clock periods.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    return max2(max2(a, b), max2(c, d));
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  // Counts down the cycles left in the current phase; 1 marks the final cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CNT_W'(1));

  // R4 R5 R7 R8: every phase is at least one cycle long
  always_comb begin
    if (!rst && load) begin
      assert_phase_nonzero_R8: assert (load_val != '0);
    end
  end

  // R7: an expired counter stays parked until the next load
  assert_timer_parked_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 14,
  parameter int SU_CYC  = 3,
  parameter int PW_CYC  = 6,
  parameter int REC_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  input  logic             phase_last,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             accept,
  output logic             cs_on_nxt,
  output logic             we_on_nxt,
  output logic             sample
);

  localparam logic [CNT_W-1:0] RD_V  = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] SU_V  = CNT_W'(SU_CYC);
  localparam logic [CNT_W-1:0] PW_V  = CNT_W'(PW_CYC);
  localparam logic [CNT_W-1:0] REC_V = CNT_W'(REC_CYC);

  seq_state_t state, state_nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  assign req_ready = (state == ST_IDLE);

  // Next state, plus the pin levels to be registered at the coming edge.
  always_comb begin
    state_nxt  = state;
    timer_load = 1'b0;
    timer_val  = '0;
    accept     = 1'b0;
    cs_on_nxt  = 1'b0;
    we_on_nxt  = 1'b0;
    sample     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          cs_on_nxt  = 1'b1;
          timer_load = 1'b1;
          if (req_write) begin
            state_nxt = ST_WSETUP;
            timer_val = SU_V;
          end else begin
            state_nxt = ST_READ;
            timer_val = RD_V;
          end
        end
      end
      ST_READ: begin
        if (phase_last) begin
          sample    = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          cs_on_nxt = 1'b1;
        end
      end
      ST_WSETUP: begin
        cs_on_nxt = 1'b1;
        if (phase_last) begin
          we_on_nxt  = 1'b1;
          timer_load = 1'b1;
          timer_val  = PW_V;
          state_nxt  = ST_WPULSE;
        end
      end
      ST_WPULSE: begin
        cs_on_nxt = 1'b1;
        if (phase_last) begin
          timer_load = 1'b1;
          timer_val  = REC_V;
          state_nxt  = ST_WRECOV;
        end else begin
          we_on_nxt = 1'b1;
        end
      end
      ST_WRECOV: begin
        if (phase_last) state_nxt = ST_IDLE;
        else            cs_on_nxt = 1'b1;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  // R3: a transfer always makes the controller busy on the next cycle
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9: no sample strobe while a write is in flight
  assert_write_no_sample_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WSETUP || state == ST_WPULSE || state == ST_WRECOV) |-> !sample);

endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              cs_on_nxt,
  input  logic              we_on_nxt,
  input  logic              sample,
  input  logic              ram_dout,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_din,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              rsp_valid,
  output logic              rsp_rdata
);

  // Every RAM pin comes straight from a flop, so no glitch reaches the chip.
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_din   <= 1'b0;
      ram_cs_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      if (accept) begin
        ram_addr <= req_addr;
        ram_din  <= req_wdata;
      end
      ram_cs_n  <= ~cs_on_nxt;
      ram_we_n  <= ~we_on_nxt;
      rsp_valid <= sample;
      if (sample) rsp_rdata <= ram_dout;
    end
  end

  // R4: write enable is low only while the chip is selected
  assert_we_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_cs_n);

  // R4: chip select was already low when write enable fell
  assert_cs_before_we_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $past(!ram_cs_n));

  // R6: address and data frozen while write enable is low
  assert_bus_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_din)));

  // R6: one cycle of recovery with an unchanged address after write enable rises
  assert_recovery_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |=> ($stable(ram_addr) && !ram_cs_n));

  // R8: the response strobe lasts one cycle and coincides with deselect
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_rsp_deselect_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ram_cs_n);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RD_CYCLE_NS = 135,
  parameter int T_RD_ACCESS_NS = 135,
  parameter int T_ADDR_SU_NS  = 10,
  parameter int T_CS_TO_WE_NS = 25,
  parameter int T_WE_PULSE_NS = 50,
  parameter int T_DATA_SU_NS  = 35,
  parameter int T_CS_TO_END_NS = 85,
  parameter int T_ADDR_TO_END_NS = 80,
  parameter int T_RECOVER_NS  = 5,
  parameter int T_DATA_HOLD_NS = 5,
  parameter int T_WR_CYCLE_NS = 135
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_din,
  input  logic              ram_dout,
  output logic              ram_cs_n,
  output logic              ram_we_n
);

  localparam int P = CLK_PERIOD_NS;

  // Read window: cycle time and access time, whichever is longer.
  localparam int RD_CYC = max2(1, max2(ns_to_cycles(T_RD_CYCLE_NS, P),
                                       ns_to_cycles(T_RD_ACCESS_NS, P)));
  // Select and address setup ahead of the write strobe.
  localparam int SU_CYC = max2(1, max2(ns_to_cycles(T_ADDR_SU_NS, P),
                                       ns_to_cycles(T_CS_TO_WE_NS, P)));
  // Strobe width: own minimum, data setup, and what the setup phase leaves
  // of the select-to-end and address-to-end spans.
  localparam int PW_CYC = max2(1, max4(ns_to_cycles(T_WE_PULSE_NS, P),
                                       ns_to_cycles(T_DATA_SU_NS, P),
                                       ns_to_cycles(T_CS_TO_END_NS, P) - SU_CYC,
                                       ns_to_cycles(T_ADDR_TO_END_NS, P) - SU_CYC));
  // Recovery: address and data hold, padded to the full write cycle time.
  localparam int REC_CYC = max2(1, max4(ns_to_cycles(T_RECOVER_NS, P),
                                        ns_to_cycles(T_DATA_HOLD_NS, P),
                                        ns_to_cycles(T_WR_CYCLE_NS, P) - SU_CYC - PW_CYC,
                                        1));
  localparam int MAX_CYC = max4(RD_CYC, SU_CYC, PW_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             phase_last;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             accept;
  logic             cs_on_nxt;
  logic             we_on_nxt;
  logic             sample;

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .last     (phase_last)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .SU_CYC  (SU_CYC),
    .PW_CYC  (PW_CYC),
    .REC_CYC (REC_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .phase_last (phase_last),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .accept     (accept),
    .cs_on_nxt  (cs_on_nxt),
    .we_on_nxt  (we_on_nxt),
    .sample     (sample)
  );

  sram_pin_stage #(
    .ADDR_W (ADDR_W)
  ) pins_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cs_on_nxt (cs_on_nxt),
    .we_on_nxt (we_on_nxt),
    .sample    (sample),
    .ram_dout  (ram_dout),
    .ram_addr  (ram_addr),
    .ram_din   (ram_din),
    .ram_cs_n  (ram_cs_n),
    .ram_we_n  (ram_we_n),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R2: deselecting the chip always releases write enable as well
  assert_idle_we_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ram_cs_n && req_ready) |-> ram_we_n);

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;

  function automatic int cdiv(input int ns);
    return (ns + 9) / 10;
  endfunction

  localparam int SU_MIN  = (cdiv(25) > cdiv(10)) ? cdiv(25) : cdiv(10);
  localparam int PW_MIN  = (cdiv(50) > cdiv(35)) ? cdiv(50) : cdiv(35);
  localparam int END_MIN = cdiv(85);
  localparam int WC_MIN  = cdiv(135);
  localparam int RD_LEN  = cdiv(135);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wdata = 1'b0;
  logic        rsp_valid;
  logic        rsp_rdata;
  logic [11:0] ram_addr;
  logic        ram_din;
  logic        ram_dout = 1'b0;
  logic        ram_cs_n;
  logic        ram_we_n;

  always #5 clk = ~clk;

  sram_cycle_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ram_addr  (ram_addr),
    .ram_din   (ram_din),
    .ram_dout  (ram_dout),
    .ram_cs_n  (ram_cs_n),
    .ram_we_n  (ram_we_n)
  );

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  logic mem    [4096];
  logic shadow [4096];
  logic exp_q  [$];

  function automatic logic seed_bit(input logic [11:0] a);
    return a[0] ^ a[3] ^ a[7];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // RAM model, pin timing monitor and scoreboard consumer, all at the falling edge.
  logic        p_cs = 1'b1, p_we = 1'b1, p_rsp = 1'b0, p_din = 1'b0;
  logic [11:0] p_addr = '0;
  int cs_cnt = 0, pre_we = 0, we_cnt = 0, post_we = 0, stable_cnt = 0;
  bit saw_we = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ram_cs_n) begin
        if (p_cs) begin
          cs_cnt = 0; pre_we = 0; we_cnt = 0; post_we = 0; saw_we = 1'b0;
        end
        cs_cnt++;
        if (!ram_we_n) begin
          if (!saw_we) begin
            saw_we = 1'b1;
            check(pre_we >= SU_MIN, "R4 setup before write enable", pre_we, SU_MIN);
          end
          we_cnt++;
        end else if (saw_we) post_we++;
        else pre_we++;
      end
      if (!ram_we_n && ram_cs_n) check(1'b0, "R4 write enable outside select", 0, 1);
      if (!ram_we_n && !p_we)
        check(ram_addr == p_addr && ram_din == p_din, "R6 bus moved under write enable",
              int'(ram_addr), int'(p_addr));
      if (ram_we_n && !p_we) begin
        check(we_cnt >= PW_MIN, "R5 pulse width", we_cnt, PW_MIN);
        check(pre_we + we_cnt >= END_MIN, "R5 select to end", pre_we + we_cnt, END_MIN);
        check(ram_addr == p_addr, "R6 address at write enable rise", int'(ram_addr), int'(p_addr));
        mem[p_addr] = p_din;
      end
      if (ram_cs_n && !p_cs) begin
        if (saw_we) begin
          check(post_we >= 1, "R6 recovery", post_we, 1);
          check(cs_cnt >= WC_MIN, "R7 write cycle", cs_cnt, WC_MIN);
          check(rsp_valid == 1'b0, "R9 write strobe", int'(rsp_valid), 0);
        end else begin
          check(cs_cnt == RD_LEN, "R8 read window", cs_cnt, RD_LEN);
          check(rsp_valid == 1'b1, "R8 strobe at deselect", int'(rsp_valid), 1);
        end
      end
      if (rsp_valid) begin
        if (p_rsp) check(1'b0, "R8 strobe longer than one cycle", 2, 1);
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected response", 1, 0);
        else begin
          logic e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R10 read data", int'(rsp_rdata), int'(e));
        end
      end
      if (!ram_cs_n) begin
        if (!p_cs && ram_addr == p_addr) stable_cnt++;
        else stable_cnt = 1;
      end else stable_cnt = 0;
      // Data is only valid once the access time has elapsed; before that it is wrong.
      ram_dout = (stable_cnt >= RD_LEN) ? mem[ram_addr] : ~mem[ram_addr];
    end
    p_cs = ram_cs_n; p_we = ram_we_n; p_rsp = rsp_valid;
    p_addr = ram_addr; p_din = ram_din;
  end

  // Driver: issues one request and records the expected read data.
  task automatic do_req(input logic [11:0] a, input logic w, input logic d);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R3 busy after transfer", int'(req_ready), 0);
    if (w) shadow[a] = d;
    else exp_q.push_back(shadow[a]);
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = seed_bit(12'(i));
      shadow[i] = seed_bit(12'(i));
    end
    repeat (4) @(negedge clk);
    check(ram_cs_n && ram_we_n && !rsp_valid, "R1 pins in reset", int'({ram_cs_n, ram_we_n, rsp_valid}), 6);
    rst = 1'b0;
    @(negedge clk);
    check(ram_cs_n && ram_we_n && !rsp_valid && req_ready, "R1 after reset",
          int'({ram_cs_n, ram_we_n, rsp_valid, req_ready}), 13);

    do_req(12'h000, 1'b1, 1'b1);
    do_req(12'hFFF, 1'b1, 1'b0);
    do_req(12'h5A5, 1'b1, ~seed_bit(12'h5A5));
    wait_idle();
    repeat (3) @(negedge clk);
    check(ram_cs_n && ram_we_n, "R2 idle pins", int'({ram_cs_n, ram_we_n}), 3);
    check(ram_addr == 12'h5A5, "R2 address held", int'(ram_addr), 'h5A5);

    do_req(12'h000, 1'b0, 1'b0);
    do_req(12'hFFF, 1'b0, 1'b0);
    do_req(12'h5A5, 1'b0, 1'b0);
    do_req(12'h123, 1'b0, 1'b0);
    do_req(12'h123, 1'b1, ~seed_bit(12'h123));
    do_req(12'h123, 1'b0, 1'b0);
    do_req(12'h000, 1'b1, 1'b0);
    do_req(12'h000, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      do_req(12'(k * 517 + 3), 1'b1, k[0]);
      do_req(12'(k * 517 + 3), 1'b0, 1'b0);
    end
    // R3: held request waits while a cycle is running
    do_req(12'h0F0, 1'b1, 1'b1);
    req_valid = 1'b1; req_addr = 12'h0F1; req_write = 1'b0;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b0 && ram_addr == 12'h0F0, "R3 held request stalled",
          int'(ram_addr), 'h0F0);
    do_req(12'h0F1, 1'b0, 1'b0);
    do_req(12'h0F0, 1'b0, 1'b0);
    wait_idle();
    repeat (3) @(negedge clk);
    check(ram_addr == 12'h0F0 && ram_cs_n, "R2 address held after read", int'(ram_addr), 'h0F0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule